// File: doc/BRIEF.md
# Bit-Synchronous Character Receiver with Sync Hunt

This block turns a bit-synchronous serial line into parallel characters. It has no start or stop bits, so it first has to find where characters begin. While hunting it slides a window over the incoming bits and compares it with one programmed sync pattern, or with two patterns that must arrive back to back. In the other mode it waits for a high level on an external sync input. Once framing is found it assembles characters of 5 to 8 data bits, least significant bit first, each optionally followed by a parity bit.

Each finished character goes into a holding register and raises a ready flag. A data read clears that flag. Parity mismatches and lost characters set sticky error flags, and an error-clear pulse drops them. A sync-detect flag reports an internal sync match and drops on a status read.

All timing is referenced to one system clock. The receive-clock rising edge arrives as a single-cycle strobe, and the line is sampled only in cycles where that strobe is high. Configuration levels and command pulses come from a separate control front end.

Top module: `sync_rx_hunt`

## Requirements
- R1: After reset `rx_ready`, `parity_err`, `overrun_err`, `sync_det` and `rx_data` are all zero, and the receiver is in the hunt state.
- R2: The number of data bits per character is `cfg_len` + 5 (00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8).
- R3: Data bits arrive least significant first. The first received bit lands in `rx_data[0]`, and bits above the character length read as zero.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_even` = 1 the data bits plus the parity bit must hold an even number of ones; with 0, an odd number. A mismatch sets `parity_err`, which stays set until an `err_clr` pulse.
- R5: In internal mode with `cfg_single_sync` = 1, each sampled bit shifts the compare window. The last character-length bits, oldest bit as bit 0, are compared with the low bits of `sync_pat1`; sync patterns carry no parity bit. A match sets `sync_det`, and assembly starts with the next sampled bit.
- R6: With `cfg_single_sync` = 0, a match on `sync_pat1` must be followed at once by the next character-length bits matching `sync_pat2`. Only then are `sync_det` set and assembly started; otherwise hunting goes on.
- R7: With `cfg_ext_sync` = 1, bits sampled during hunt are ignored. A high `ext_sync_in` during hunt starts assembly with the next sampled bit, and `sync_det` stays low.
- R8: A `stat_rd` pulse clears `sync_det`. A new sync event in the same cycle wins.
- R9: `rx_ready` rises in the cycle after the last bit of a character is sampled, and `rx_data` is loaded in that same cycle. A `data_rd` pulse clears `rx_ready`, except when a character completes in the same cycle.
- R10: If a character completes while `rx_ready` is still set, `rx_data` takes the new character and `overrun_err` is set until an `err_clr` pulse.
- R11: A `hunt_cmd` pulse sends the receiver back to hunting from any state. A partly assembled character is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe marking a receive-clock rising edge |
| rx_line | input | 1 | Serial data line |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_ext_sync | input | 1 | 1 = external sync input, 0 = pattern hunt |
| cfg_single_sync | input | 1 | 1 = one sync pattern, 0 = two patterns in sequence |
| sync_pat1 | input | 8 | First sync pattern |
| sync_pat2 | input | 8 | Second sync pattern |
| ext_sync_in | input | 1 | External sync level |
| hunt_cmd | input | 1 | Pulse: return to hunting |
| err_clr | input | 1 | Pulse: clear parity and overrun flags |
| stat_rd | input | 1 | Pulse: status read, clears sync-detect |
| data_rd | input | 1 | Pulse: data read, clears ready |
| rx_data | output | 8 | Last completed character, right-aligned |
| rx_ready | output | 1 | Character waiting to be read |
| parity_err | output | 1 | Sticky parity error |
| overrun_err | output | 1 | Sticky overrun error |
| sync_det | output | 1 | Internal sync found |

## Verification
Hunting is driven with runs of idle ones ahead of the pattern. A sliding window that fires before the last pattern bit, or on a shifted copy, would then produce a character nobody expects. In two-pattern mode the first pattern is sent followed by a wrong character, which separates a receiver that demands strict adjacency from one that accepts the two patterns anywhere. Characters of 5, 7 and 8 bits, with even, odd and no parity and with both good and corrupted parity bits, separate the bit-order, zero-fill and parity-sense choices. Back-to-back characters without reads expose overrun. An external-sync run with an abort in mid-character shows that stray bits neither start nor leak into later characters.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_HUNT2 = 2'd1,
    ST_ASSY  = 2'd2
  } rx_state_e;

  localparam int MIN_CHAR = 5;

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'(len) + 4'(MIN_CHAR);
  endfunction

endpackage

// File: rtl/sync_rx_window.sv
module sync_rx_window #(
  parameter int W     = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] cw,
  input  logic [W-1:0]     pat1,
  input  logic [W-1:0]     pat2,
  output logic [W-1:0]     data_now,
  output logic [W-1:0]     data_next,
  output logic             match1,
  output logic             match2
);

  logic [W-1:0]     win_q;
  logic [W-1:0]     win_d;
  logic [CNT_W-1:0] sh_amt;
  logic [W-1:0]     mask;

  assign win_d     = {bit_in, win_q[W-1:1]};
  assign sh_amt    = CNT_W'(W) - cw;
  assign mask      = (W'(1) << cw) - W'(1);
  assign data_now  = win_q >> sh_amt;
  assign data_next = win_d >> sh_amt;
  assign match1    = (data_next == (pat1 & mask));
  assign match2    = (data_next == (pat2 & mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (shift_en) begin
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/sync_rx_flags.sv
module sync_rx_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         char_done,
  input  logic [W-1:0] char_data,
  input  logic         par_bad,
  input  logic         sync_hit,
  input  logic         stat_rd,
  input  logic         data_rd,
  input  logic         err_clr,
  output logic [W-1:0] rx_data,
  output logic         rx_ready,
  output logic         parity_err,
  output logic         overrun_err,
  output logic         sync_det
);

  logic [W-1:0] data_d;
  logic         rdy_d, perr_d, oerr_d, sdet_d;

  always_comb begin
    data_d = rx_data;
    rdy_d  = rx_ready && !data_rd;
    perr_d = parity_err && !err_clr;
    oerr_d = overrun_err && !err_clr;
    sdet_d = sync_det && !stat_rd;
    if (char_done) begin
      data_d = char_data;
      rdy_d  = 1'b1;
      if (rx_ready && !data_rd) oerr_d = 1'b1;
      if (par_bad) perr_d = 1'b1;
    end
    if (sync_hit) sdet_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      parity_err  <= 1'b0;
      overrun_err <= 1'b0;
      sync_det    <= 1'b0;
    end else begin
      rx_data     <= data_d;
      rx_ready    <= rdy_d;
      parity_err  <= perr_d;
      overrun_err <= oerr_d;
      sync_det    <= sdet_d;
    end
  end

endmodule

// File: rtl/sync_rx_hunt.sv
module sync_rx_hunt
  import sync_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_en,
  input  logic         rx_line,
  input  logic [1:0]   cfg_len,
  input  logic         cfg_par_en,
  input  logic         cfg_par_even,
  input  logic         cfg_ext_sync,
  input  logic         cfg_single_sync,
  input  logic [W-1:0] sync_pat1,
  input  logic [W-1:0] sync_pat2,
  input  logic         ext_sync_in,
  input  logic         hunt_cmd,
  input  logic         err_clr,
  input  logic         stat_rd,
  input  logic         data_rd,
  output logic [W-1:0] rx_data,
  output logic         rx_ready,
  output logic         parity_err,
  output logic         overrun_err,
  output logic         sync_det
);

  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cw;
  logic             win_en, match1, match2;
  logic [W-1:0]     data_now, data_next, char_data;
  logic             char_done, par_bad, sync_hit, exp_par;

  assign cw        = CNT_W'(char_bits(cfg_len));
  assign char_data = cfg_par_en ? data_now : data_next;
  assign exp_par   = cfg_par_even ? (^data_now) : ~(^data_now);

  sync_rx_window #(.W(W), .CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (win_en),
    .bit_in    (rx_line),
    .cw        (cw),
    .pat1      (sync_pat1),
    .pat2      (sync_pat2),
    .data_now  (data_now),
    .data_next (data_next),
    .match1    (match1),
    .match2    (match2)
  );

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    win_en    = 1'b0;
    char_done = 1'b0;
    par_bad   = 1'b0;
    sync_hit  = 1'b0;
    if (hunt_cmd) begin
      st_d  = ST_HUNT;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          if (cfg_ext_sync) begin
            if (ext_sync_in) begin
              st_d  = ST_ASSY;
              cnt_d = '0;
            end
          end else if (sample_en) begin
            win_en = 1'b1;
            if ((cnt_q >= cw - CNT_W'(1)) && match1) begin
              cnt_d = '0;
              if (cfg_single_sync) begin
                st_d     = ST_ASSY;
                sync_hit = 1'b1;
              end else begin
                st_d = ST_HUNT2;
              end
            end else if (cnt_q != CNT_MAX) begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_HUNT2: begin
          if (sample_en) begin
            win_en = 1'b1;
            if (cnt_q == cw - CNT_W'(1)) begin
              cnt_d = '0;
              if (match2) begin
                st_d     = ST_ASSY;
                sync_hit = 1'b1;
              end else if (!match1) begin
                st_d  = ST_HUNT;
                cnt_d = cw;
              end
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_ASSY: begin
          if (sample_en) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q < cw) begin
              win_en = 1'b1;
              if ((cnt_q == cw - CNT_W'(1)) && !cfg_par_en) begin
                char_done = 1'b1;
                cnt_d     = '0;
              end
            end else begin
              char_done = 1'b1;
              par_bad   = (rx_line != exp_par);
              cnt_d     = '0;
            end
          end
        end
        default: begin
          st_d  = ST_HUNT;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  sync_rx_flags #(.W(W)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_done   (char_done),
    .char_data   (char_data),
    .par_bad     (par_bad),
    .sync_hit    (sync_hit),
    .stat_rd     (stat_rd),
    .data_rd     (data_rd),
    .err_clr     (err_clr),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .parity_err  (parity_err),
    .overrun_err (overrun_err),
    .sync_det    (sync_det)
  );

endmodule

// File: rtl/sync_rx_hunt_chk.sv
module sync_rx_hunt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sample_en,
  input logic         cfg_par_en,
  input logic         cfg_ext_sync,
  input logic         stat_rd,
  input logic         data_rd,
  input logic         err_clr,
  input logic [W-1:0] rx_data,
  input logic         rx_ready,
  input logic         parity_err,
  input logic         overrun_err,
  input logic         sync_det
);

  // R10
  overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(rx_ready));

  // R7
  sync_det_internal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_det) |-> !$past(cfg_ext_sync));

  // R5
  sync_det_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_det) |-> $past(sample_en));

  // R8
  sync_det_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_det) |-> $past(stat_rd));

  // R9
  ready_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(data_rd));

  // R9
  data_load_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_ready);

  // R4
  parity_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err) |-> $past(cfg_par_en));

  // R4
  parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parity_err) |-> $past(err_clr));

endmodule

bind sync_rx_hunt sync_rx_hunt_chk #(.W(W)) u_chk (.*);

// File: tb/sync_rx_hunt_test.sv
module sync_rx_hunt_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_en = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_ext_sync = 1'b0;
  logic       cfg_single_sync = 1'b1;
  logic [7:0] sync_pat1 = 8'h16;
  logic [7:0] sync_pat2 = 8'h27;
  logic       ext_sync_in = 1'b0;
  logic       hunt_cmd = 1'b0;
  logic       err_clr = 1'b0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, parity_err, overrun_err, sync_det;

  int n_chk = 0;
  int n_fail = 0;
  logic mon_en = 1'b1;
  logic [8:0] expq[$];

  always #5 clk = ~clk;

  sync_rx_hunt uut (.*);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_line   = b;
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  // pushes the expected item, then drives data bits and the optional parity bit
  task automatic send_char(input logic [7:0] d, input int n, input logic bad);
    logic p;
    p = cfg_par_even ? ^d : ~^d;
    if (bad) p = ~p;
    expq.push_back({bad && cfg_par_en, d});
    send_bits(d, n);
    if (cfg_par_en) send_bit(p);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  // monitor: pops the scoreboard when a character shows up
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rx_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9 unexpected character", rx_data, 0);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          check(rx_data == e[7:0], "R3 data", rx_data, e[7:0]);
          check(parity_err == e[8], "R4 parity flag", parity_err, e[8]);
        end
        data_rd = 1'b1;
        err_clr = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        err_clr = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rx_ready == 0, "R1 ready", rx_ready, 0);
    check(sync_det == 0, "R1 sync_det", sync_det, 0);
    check(parity_err == 0, "R1 parity", parity_err, 0);
    check(overrun_err == 0, "R1 overrun", overrun_err, 0);
    check(rx_data == 0, "R1 data", rx_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 single sync, 8 bits, idle ones first
    send_bits(8'hFF, 8);
    check(sync_det == 0, "R5 no early sync", sync_det, 0);
    send_bits(8'h16, 8);
    check(sync_det == 1, "R5 sync found", sync_det, 1);
    send_char(8'hA5, 8, 1'b0);
    send_char(8'h3C, 8, 1'b0);
    // R8 status read clears sync-detect
    pulse(stat_rd);
    @(negedge clk);
    check(sync_det == 0, "R8 cleared", sync_det, 0);

    // R10 overrun
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    check(rx_ready == 1, "R10 ready", rx_ready, 1);
    check(overrun_err == 1, "R10 overrun", overrun_err, 1);
    check(rx_data == 8'h22, "R10 newest kept", rx_data, 8'h22);
    pulse(data_rd);
    @(negedge clk);
    check(rx_ready == 0, "R9 read clears", rx_ready, 0);
    check(overrun_err == 1, "R10 sticky", overrun_err, 1);
    pulse(err_clr);
    @(negedge clk);
    check(overrun_err == 0, "R10 cleared", overrun_err, 0);
    mon_en = 1'b1;

    // R6 two patterns, first followed by wrong character
    cfg_single_sync = 1'b0;
    pulse(hunt_cmd);
    send_bits(8'hFF, 8);
    send_bits(8'h16, 8);
    send_bits(8'h00, 8);
    send_bits(8'hFF, 8);
    check(sync_det == 0, "R6 not adjacent", sync_det, 0);
    check(rx_ready == 0, "R6 no assembly", rx_ready, 0);
    send_bits(8'h16, 8);
    check(sync_det == 0, "R6 half pair", sync_det, 0);
    send_bits(8'h27, 8);
    check(sync_det == 1, "R6 pair found", sync_det, 1);
    send_char(8'hC3, 8, 1'b0);
    pulse(stat_rd);

    // R2 five-bit characters with even parity, R3 zero fill
    cfg_single_sync = 1'b1;
    cfg_len = 2'b00;
    cfg_par_en = 1'b1;
    cfg_par_even = 1'b1;
    pulse(hunt_cmd);
    send_bits(8'hFF, 8);
    send_bits(8'h16, 5);
    check(sync_det == 1, "R2 five-bit sync", sync_det, 1);
    send_char(8'h0B, 5, 1'b0);
    send_char(8'h05, 5, 1'b1);
    // R2 seven-bit, odd parity
    cfg_len = 2'b10;
    cfg_par_even = 1'b0;
    pulse(hunt_cmd);
    send_bits(8'hFF, 8);
    send_bits(8'h16, 7);
    send_char(8'h55, 7, 1'b0);
    send_char(8'h2A, 7, 1'b1);
    send_char(8'h01, 7, 1'b0);
    pulse(stat_rd);

    // R7 external sync
    cfg_len = 2'b11;
    cfg_par_en = 1'b0;
    cfg_ext_sync = 1'b1;
    pulse(hunt_cmd);
    send_bits(8'h16, 8);
    send_bits(8'h00, 8);
    check(rx_ready == 0, "R7 bits ignored", rx_ready, 0);
    pulse(ext_sync_in);
    send_char(8'h81, 8, 1'b0);
    check(sync_det == 0, "R7 sync_det low", sync_det, 0);
    // R11 abort mid-character
    send_bits(8'h0F, 4);
    pulse(hunt_cmd);
    send_bits(8'hF0, 8);
    check(rx_ready == 0, "R11 abort", rx_ready, 0);
    pulse(ext_sync_in);
    send_char(8'h5A, 8, 1'b0);

    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R9 all received", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule